// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the data-access side of a 32-bit core and a word-addressed data memory. A core request gives a base value, a signed 16-bit displacement, an access code and, for stores, the data to write. The unit forms the effective address, converts it to a word address plus a byte offset, and builds one memory command. A store command carries per-lane write enables and write data copied across every lane the access could hit. A load command carries no enables. When the load word comes back, the unit picks the addressed byte or halfword and widens it to 32 bits with sign or zero fill.

Byte numbering is big-endian: offset 0 is data bits 31:24, and `mem_be[i]` covers data bits 8i+7:8i. A word access whose two low address bits are not both zero is misaligned, as is a halfword access at an odd address. Such an access is still passed on, but it is flagged and has no write enables.

Every data path uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls while the one-entry command register is full and `mem_ready` is low. It also falls for loads while the number of loads taken but not yet answered equals `MAX_LOADS`. A pending command holds all of its fields stable until `mem_ready` accepts it. Memory answers loads in issue order. The response channel passes straight through: `ld_valid` follows `rsp_valid` and `rsp_ready` follows `ld_ready`.

Top module: `lsa_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits. `mem_addr` carries its bits 31:2, and its bits 1:0 are the byte offset.
- R2: The access code is `req_size`. Bits 1:0 give the width: 00 byte, 01 halfword, 10 or 11 word. Bit 2 set selects zero extension on loads and is ignored for stores. A store has `mem_write`=1. A load has `mem_write`=0, `mem_be`=0000 and `mem_wdata`=0.
- R3: Aligned store enables are big-endian. A byte at offset k sets only `mem_be[3-k]`. A halfword at offset 0 gives 1100 and at offset 2 gives 0011. A word gives 1111.
- R4: Store data is copied across lanes. A byte store drives `req_wdata[7:0]` on all four lanes. A halfword store drives `req_wdata[15:0]` on both halves. A word store drives `req_wdata` unchanged.
- R5: A word access at a nonzero offset, or a halfword access at an odd offset, sets `mem_misalign` and forces `mem_be` to 0000. Byte accesses are never misaligned.
- R6: A byte load returns the byte at bits 31-8k:24-8k of the returned word, sign-extended when bit 2 of the code is 0 and zero-extended when it is 1.
- R7: A halfword load at offset 0 returns bits 31:16 and at offset 2 returns bits 15:0. It is sign-extended or zero-extended by the same rule as R6.
- R8: An aligned word load returns the memory word unchanged. `ld_misalign` carries the misalignment flag of the load being answered.
- R9: While `mem_valid` is high and `mem_ready` is low, the command fields stay stable and `req_ready` is low.
- R10: Load results come back in request order. `req_ready` is low for a load while `MAX_LOADS` loads are unanswered.
- R11: After reset `mem_valid` is low, no load is outstanding and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request can be taken |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Access code: bits 1:0 width, bit 2 unsigned load |
| req_base | input | 32 | Base operand |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory takes the command |
| mem_write | output | 1 | Command is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_misalign | output | 1 | Command is misaligned |
| rsp_valid | input | 1 | Memory load word valid |
| rsp_ready | output | 1 | Load word can be taken |
| rsp_rdata | input | 32 | Memory load word |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Core takes the load result |
| ld_data | output | 32 | Extended load result |
| ld_misalign | output | 1 | Load result came from a misaligned access |

## Verification
The bench builds the unit with the default 32-bit data and address widths and `MAX_LOADS` set to 2. That makes the limit on unanswered loads reachable after just two back-to-back loads, so the stall and the in-order return can both be checked. Each access code is swept over every byte offset and over three base and displacement pairs, including a negative displacement and one that crosses the 32-bit wrap. The two load words have bytes with the sign bit set and clear in alternating lanes, so both extension results appear at every offset.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    W_BYTE  = 2'b00,
    W_HALF  = 2'b01,
    W_WORD  = 2'b10,
    W_WORD2 = 2'b11
  } width_e;

  function automatic logic is_half(input width_e w);
    return w == W_HALF;
  endfunction

  function automatic logic is_byte(input width_e w);
    return w == W_BYTE;
  endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign ea       = base + disp_ext;
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  width_e              width,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   data,
  output logic                misalign
);
  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);
  localparam int HIDX_W = OFF_W - 1;

  always_comb begin
    unique case (width)
      W_BYTE:  misalign = 1'b0;
      W_HALF:  misalign = off[0];
      default: misalign = |off;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int K = LANES - 1 - i;
    logic hit;
    always_comb begin
      unique case (width)
        W_BYTE:  hit = (off == OFF_W'(K));
        W_HALF:  hit = (off[OFF_W-1:1] == HIDX_W'(K / 2));
        default: hit = 1'b1;
      endcase
    end
    assign be[i] = hit && !misalign;
  end

  always_comb begin
    unique case (width)
      W_BYTE:  data = {LANES{wdata[7:0]}};
      W_HALF:  data = {HALVES{wdata[15:0]}};
      default: data = wdata;
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  width_e                      width,
  input  logic                        uns,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           data
);
  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);

  logic [7:0]  lane_b [LANES];
  logic [15:0] lane_h [HALVES];
  logic [7:0]  bsel;
  logic [15:0] hsel;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign lane_b[k] = rdata[8*(LANES-1-k) +: 8];
  end

  for (genvar k = 0; k < HALVES; k++) begin : g_half
    assign lane_h[k] = rdata[16*(HALVES-1-k) +: 16];
  end

  assign bsel = lane_b[off];
  assign hsel = lane_h[off[OFF_W-1:1]];

  always_comb begin
    unique case (width)
      W_BYTE:  data = {{(DATA_W-8){bsel[7] & ~uns}}, bsel};
      W_HALF:  data = {{(DATA_W-16){hsel[15] & ~uns}}, hsel};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/lsa_tag_fifo.sv
module lsa_tag_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slots[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DISP_W    = 16,
  parameter int MAX_LOADS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_store,
  input  logic [2:0]                      req_size,
  input  logic [ADDR_W-1:0]               req_base,
  input  logic [DISP_W-1:0]               req_disp,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            mem_valid,
  input  logic                            mem_ready,
  output logic                            mem_write,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W/8-1:0]             mem_be,
  output logic [DATA_W-1:0]               mem_wdata,
  output logic                            mem_misalign,
  input  logic                            rsp_valid,
  output logic                            rsp_ready,
  input  logic [DATA_W-1:0]               rsp_rdata,
  output logic                            ld_valid,
  input  logic                            ld_ready,
  output logic [DATA_W-1:0]               ld_data,
  output logic                            ld_misalign
);
  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = 1 + 1 + 2 + OFF_W;

  // request decode
  width_e             rq_width;
  logic               rq_uns;
  logic [ADDR_W-1:0]  rq_ea;
  logic [OFF_W-1:0]   rq_off;
  logic [LANES-1:0]   st_be;
  logic [DATA_W-1:0]  st_data;
  logic               rq_mis;
  logic               accept;

  assign rq_width = width_e'(req_size[1:0]);
  assign rq_uns   = req_size[2];
  assign rq_off   = rq_ea[OFF_W-1:0];

  lsa_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .base (req_base),
    .disp (req_disp),
    .ea   (rq_ea)
  );

  lsa_store_lane #(.DATA_W(DATA_W)) u_store (
    .width    (rq_width),
    .off      (rq_off),
    .wdata    (req_wdata),
    .be       (st_be),
    .data     (st_data),
    .misalign (rq_mis)
  );

  // tag queue of loads awaiting data
  logic [TAG_W-1:0] tag_in, tag_head;
  logic             tag_full, tag_empty, tag_pop;

  assign tag_in  = {rq_mis, rq_uns, req_size[1:0], rq_off};
  assign tag_pop = rsp_valid && ld_ready;

  lsa_tag_fifo #(.W(TAG_W), .DEPTH(MAX_LOADS)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept && !req_store),
    .din   (tag_in),
    .pop   (tag_pop),
    .dout  (tag_head),
    .full  (tag_full),
    .empty (tag_empty)
  );

  // command register stage
  logic               cmd_v;
  logic               cmd_write;
  logic [WADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]   cmd_be;
  logic [DATA_W-1:0]  cmd_data;
  logic               cmd_mis;
  logic               slot_free;

  assign slot_free = !cmd_v || mem_ready;
  assign req_ready = slot_free && (req_store || !tag_full);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v     <= 1'b0;
      cmd_write <= 1'b0;
      cmd_addr  <= '0;
      cmd_be    <= '0;
      cmd_data  <= '0;
      cmd_mis   <= 1'b0;
    end else if (accept) begin
      cmd_v     <= 1'b1;
      cmd_write <= req_store;
      cmd_addr  <= rq_ea[ADDR_W-1:OFF_W];
      cmd_be    <= req_store ? st_be : '0;
      cmd_data  <= req_store ? st_data : '0;
      cmd_mis   <= rq_mis;
    end else if (mem_ready) begin
      cmd_v     <= 1'b0;
    end
  end

  assign mem_valid    = cmd_v;
  assign mem_write    = cmd_write;
  assign mem_addr     = cmd_addr;
  assign mem_be       = cmd_be;
  assign mem_wdata    = cmd_data;
  assign mem_misalign = cmd_mis;

  // load return path
  width_e           hd_width;
  logic             hd_uns;
  logic [OFF_W-1:0] hd_off;

  assign hd_off   = tag_head[OFF_W-1:0];
  assign hd_width = width_e'(tag_head[OFF_W +: 2]);
  assign hd_uns   = tag_head[OFF_W+2];

  lsa_load_extract #(.DATA_W(DATA_W)) u_load (
    .width (hd_width),
    .uns   (hd_uns),
    .off   (hd_off),
    .rdata (rsp_rdata),
    .data  (ld_data)
  );

  assign ld_valid    = rsp_valid;
  assign rsp_ready   = ld_ready;
  assign ld_misalign = tag_head[OFF_W+3];
endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
  parameter int WADDR_W   = 30,
  parameter int LANES     = 4,
  parameter int DATA_W    = 32,
  parameter int MAX_LOADS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic               mem_write,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]   mem_be,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               mem_misalign,
  input logic               rsp_valid,
  input logic               rsp_ready
);
  logic [7:0] issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued <= '0;
    else begin
      unique case ({mem_valid && mem_ready && !mem_write, rsp_valid && rsp_ready})
        2'b10:   issued <= issued + 1'b1;
        2'b01:   issued <= issued - 1'b1;
        default: issued <= issued;
      endcase
    end
  end

  p_idle_after_reset_r11: assert property (@(posedge clk) !rst_n |=> !mem_valid);

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
      && $stable(mem_wdata) && $stable(mem_write) && $stable(mem_misalign));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !req_ready);

  p_misalign_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_misalign |-> mem_be == '0);

  p_load_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> mem_be == '0 && mem_wdata == '0);

  p_lane_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && !mem_misalign |->
      ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == LANES));

  p_load_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issued <= 8'(MAX_LOADS));
endmodule

bind lsa_unit lsa_unit_chk #(
  .WADDR_W   (WADDR_W),
  .LANES     (LANES),
  .DATA_W    (DATA_W),
  .MAX_LOADS (MAX_LOADS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_write    (mem_write),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .mem_wdata    (mem_wdata),
  .mem_misalign (mem_misalign),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready)
);

// File: tb/tb_lsa_unit.sv
module tb_lsa_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [15:0] req_disp = '0;
  logic        mem_valid, mem_ready = 1'b0, mem_write, mem_misalign;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_rdata = '0;
  logic        ld_valid, ld_ready = 1'b0, ld_misalign;
  logic [31:0] ld_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lsa_unit #(.MAX_LOADS(2)) dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] base_of(input int s);
    case (s)
      0:       return 32'h1000_0100;
      1:       return 32'h0000_0040;
      default: return 32'hFFFF_FFF8;
    endcase
  endfunction

  function automatic logic [15:0] disp_of(input int s);
    case (s)
      0:       return 16'h0024;
      1:       return 16'hFFF0;
      default: return 16'h7FF0;
    endcase
  endfunction

  // expected store enables, R3/R5
  function automatic logic [3:0] exp_be(input logic [1:0] w, input logic [1:0] off);
    if (w == 2'b00) return 4'b1000 >> off;
    if (w == 2'b01) return off[0] ? 4'b0000 : (off[1] ? 4'b0011 : 4'b1100);
    return (off != 0) ? 4'b0000 : 4'b1111;
  endfunction

  function automatic logic exp_mis(input logic [1:0] w, input logic [1:0] off);
    if (w == 2'b00) return 1'b0;
    if (w == 2'b01) return off[0];
    return off != 0;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [2:0] c, input logic [1:0] off, input logic [31:0] rd);
    logic [7:0]  b;
    logic [15:0] h;
    b = 8'((rd >> (8 * (3 - off))) & 32'hFF);
    h = 16'((rd >> (16 * (1 - off[1]))) & 32'hFFFF);
    if (c[1:0] == 2'b00) return c[2] ? {24'h0, b} : {{24{b[7]}}, b};
    if (c[1:0] == 2'b01) return c[2] ? {16'h0, h} : {{16{h[15]}}, h};
    return rd;
  endfunction

  task automatic one_access(input bit st, input logic [2:0] code, input int s, input int off,
                            input logic [31:0] wd, input logic [31:0] rd);
    logic [31:0] ea;
    logic [1:0]  o;
    logic [31:0] exp_wd;
    ea = base_of(s) + 32'(off) + {{16{disp_of(s)[15]}}, disp_of(s)};
    o  = ea[1:0];
    @(negedge clk);
    req_store = st; req_size = code; req_base = base_of(s) + 32'(off);
    req_disp = disp_of(s); req_wdata = wd; req_valid = 1'b1; mem_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_valid === 1'b1, "R9 command present", {31'b0, mem_valid}, 32'd1);
    check(mem_addr === ea[31:2], "R1 word address", {2'b0, mem_addr}, {2'b0, ea[31:2]});
    check(mem_misalign === exp_mis(code[1:0], o), "R5 misalign flag", {31'b0, mem_misalign},
          {31'b0, exp_mis(code[1:0], o)});
    if (st) begin
      exp_wd = (code[1:0] == 2'b00) ? {4{wd[7:0]}} : (code[1:0] == 2'b01) ? {2{wd[15:0]}} : wd;
      check(mem_write === 1'b1, "R2 write flag", {31'b0, mem_write}, 32'd1);
      check(mem_be === exp_be(code[1:0], o), "R3 R5 lane enables", {28'b0, mem_be},
            {28'b0, exp_be(code[1:0], o)});
      check(mem_wdata === exp_wd, "R4 replicated data", mem_wdata, exp_wd);
    end else begin
      check(mem_write === 1'b0 && mem_be === 4'b0 && mem_wdata === 32'h0, "R2 load command",
            {mem_wdata[27:0], mem_be}, 32'h0);
    end
    @(posedge clk);
    @(negedge clk);
    check(mem_valid === 1'b1 && mem_addr === ea[31:2] && req_ready === 1'b0, "R9 hold under stall",
          {2'b0, mem_addr}, {2'b0, ea[31:2]});
    mem_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_ready = 1'b0;
    check(mem_valid === 1'b0, "R9 command drained", {31'b0, mem_valid}, 32'd0);
    if (!st) begin
      rsp_valid = 1'b1; rsp_rdata = rd; ld_ready = 1'b1;
      #1;
      check(ld_valid === 1'b1, "R10 result valid", {31'b0, ld_valid}, 32'd1);
      check(ld_misalign === exp_mis(code[1:0], o), "R8 load misalign", {31'b0, ld_misalign},
            {31'b0, exp_mis(code[1:0], o)});
      if (!exp_mis(code[1:0], o)) begin
        if (code[1:0] == 2'b00)      check(ld_data === exp_ld(code, o, rd), "R6 byte load", ld_data, exp_ld(code, o, rd));
        else if (code[1:0] == 2'b01) check(ld_data === exp_ld(code, o, rd), "R7 half load", ld_data, exp_ld(code, o, rd));
        else                         check(ld_data === rd, "R8 word load", ld_data, rd);
      end
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0; ld_ready = 1'b0;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [2:0] ldc [5];
    ldc[0] = 3'b000; ldc[1] = 3'b100; ldc[2] = 3'b001; ldc[3] = 3'b101; ldc[4] = 3'b010;
    repeat (3) @(negedge clk);
    check(mem_valid === 1'b0 && req_ready === 1'b1 && ld_valid === 1'b0, "R11 reset state",
          {29'b0, mem_valid, req_ready, ld_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_valid === 1'b0 && req_ready === 1'b1, "R11 idle after release",
          {30'b0, mem_valid, req_ready}, 32'h1);

    for (int s = 0; s < 3; s++)
      for (int off = 0; off < 4; off++) begin
        for (int w = 0; w < 3; w++)
          one_access(1'b1, {s[0], 2'(w)}, s, off, 32'hC3A5_5A3C ^ (32'(s) << 4), 32'h0);
        for (int c = 0; c < 5; c++)
          one_access(1'b0, ldc[c], s, off, 32'hFFFF_FFFF,
                     (s == 1) ? 32'h3C91_4EF2 : 32'h8A7B_C65D);
      end

    // R10: two loads fill the queue, third waits, answers in order
    @(negedge clk);
    mem_ready = 1'b1; req_store = 1'b0; req_disp = 16'h0;
    req_size = 3'b100; req_base = 32'h0000_2000; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_size = 3'b000; req_base = 32'h0000_2003;
    @(posedge clk);
    @(negedge clk);
    req_size = 3'b010; req_base = 32'h0000_2008;
    check(req_ready === 1'b0, "R10 load limit stall", {31'b0, req_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; mem_ready = 1'b0;
    rsp_valid = 1'b1; rsp_rdata = 32'hF011_22E3; ld_ready = 1'b1;
    #1;
    check(ld_data === 32'h0000_00F0, "R10 first answer", ld_data, 32'h0000_00F0);
    @(posedge clk);
    @(negedge clk);
    check(ld_data === 32'hFFFF_FFE3, "R10 second answer", ld_data, 32'hFFFF_FFE3);
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0; ld_ready = 1'b0;
    check(req_ready === 1'b1, "R10 limit released", {31'b0, req_ready}, 32'd1);

    done = 1;
    finish_up();
  end
endmodule